// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-up to normal operation. After a synchronous reset it keeps the clock-enable pin low and sends no-operation codes on the command bus. It waits for a start request, which counts only while the clock-stable qualifier is high. It then holds clock enable low for a programmable power-up interval, given in nanoseconds and converted to clock cycles. After that it steps through a fixed list of commands:

- a no-operation with clock enable raised;
- a precharge of all banks;
- an extended-mode write that enables the delay-locked loop;
- a mode write that resets that loop;
- a second precharge of all banks;
- two auto refreshes;
- a final mode write with the loop-reset bit cleared.

Each command is followed by its minimum spacing, set by a counter.

Once the last spacing has passed, and at least the DLL lock window has passed since the loop-reset write, the block raises its done flag. It then sends only no-operation codes. The done flag is the select for an external multiplexer that hands the command bus to the normal-operation controller. The command spacings `T_RP`, `T_MRD` and `T_RFC` must each be 2 or more. `ADDR_W` must be at least 11.

Top module: `ddr_init_seq`

## Requirements
- R1: While in reset, and afterwards until a start request arrives with `clk_ok_i` high, `cke_o` is 0. The command code {cs_n,ras_n,cas_n,we_n} is 0111 (NOP) and `init_done_o` is 0. A start request while `clk_ok_i` is 0 is ignored.
- R2: The start request is taken at a clock edge. `cke_o` then stays 0 for exactly PWR_CYC = ceil(POWERUP_NS*1000/CLK_PS) cycles. In the next cycle `cke_o` goes to 1 with a NOP, and it stays 1 until reset.
- R3: One cycle after `cke_o` rises, the block issues PRECHARGE ALL: code 0010, address bit 10 set, all other address bits 0, bank 0.
- R4: T_RP cycles after that precharge, the block writes the extended mode register: code 0000, bank 01, address EXT_MODE.
- R5: T_MRD cycles after the extended write, the block writes the base mode register with the DLL reset: code 0000, bank 00. The address has bit 8 = 1, bits 6:4 = CAS_CODE, bit 3 = 0, bits 2:0 = BURST_CODE and all other bits 0.
- R6: T_MRD cycles after the DLL-reset write, the block issues a second PRECHARGE ALL, encoded as in R3.
- R7: T_RP cycles after the second precharge, the block issues AUTO REFRESH (code 0001, bank 0, address 0). It issues a second AUTO REFRESH T_RFC cycles after the first.
- R8: T_RFC cycles after the second refresh, the block writes the base mode register as in R5 but with bit 8 = 0.
- R9: `init_done_o` first goes high in the later of two cycles: T_MRD cycles after the final write, or DLL_CYC+1 cycles after the DLL-reset write. It then stays high until reset. While it is high the command is NOP and a start request has no effect.
- R10: Every cycle other than the seven command cycles carries NOP. Exactly seven non-NOP commands appear from start to done.
- R11: A synchronous reset in the middle of the sequence returns the block to the R1 state in the next cycle. A new start repeats the sequence with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin initialization |
| clk_ok_i | input | 1 | Clock-stable qualifier for start_i |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode-register value |
| init_done_o | output | 1 | Initialization finished; command bus may be handed over |

## Verification
The outputs are decoded directly from the state register. A wrong state or a skipped step therefore shows in the same cycle as a wrong command code, bank or address value, or as clock enable moving at the wrong time. A counter that is off by one shifts the spacing of the next command by one cycle. A loaded value that is wrong in the DLL-window counter moves the rise of the done flag, possibly long after the last command. For that reason the done cycle is checked exactly against the DLL-reset write, and not only against the final write.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int CLK_PS     = 7500,
  parameter int POWERUP_NS = 200000,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 10,
  parameter int DLL_CYC    = 200,
  parameter logic [2:0] BURST_CODE = 3'b010,
  parameter logic [2:0] CAS_CODE   = 3'b010,
  parameter logic [ADDR_W-1:0] EXT_MODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clk_ok_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int PWR_CYC = (POWERUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAX_WAIT = (PWR_CYC > T_RFC) ? PWR_CYC : T_RFC;
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam int DW = $clog2(DLL_CYC + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [ADDR_W-1:0] MODE_BASE =
    ADDR_W'({CAS_CODE, 1'b0, BURST_CODE});
  localparam logic [ADDR_W-1:0] BIT8  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] BIT10 = ADDR_W'(1) << 10;

  typedef enum logic [4:0] {
    S_IDLE, S_PWAIT, S_NOP,
    S_PRE1, S_WRP1, S_EMR, S_WMR1, S_MRR, S_WMR2,
    S_PRE2, S_WRP2, S_REF1, S_WRF1, S_REF2, S_WRF2,
    S_MRF, S_WMR3, S_DONE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dll;
  logic [3:0] cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
      dll <= '0;
    end else begin
      if (dll != '0) dll <= dll - 1'b1;
      case (st)
        S_IDLE: if (start_i && clk_ok_i) begin
          st  <= S_PWAIT;
          cnt <= CW'(PWR_CYC - 1);
        end
        S_NOP: st <= S_PRE1;
        S_PRE1, S_PRE2: begin
          st  <= st_t'(st + 1'b1);
          cnt <= CW'(T_RP - 2);
        end
        S_EMR, S_MRF: begin
          st  <= st_t'(st + 1'b1);
          cnt <= CW'(T_MRD - 2);
        end
        S_MRR: begin
          st  <= S_WMR2;
          cnt <= CW'(T_MRD - 2);
          dll <= DW'(DLL_CYC - 1);
        end
        S_REF1, S_REF2: begin
          st  <= st_t'(st + 1'b1);
          cnt <= CW'(T_RFC - 2);
        end
        S_WMR3: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (dll == '0) st <= S_DONE;
        end
        S_DONE: st <= S_DONE;
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else st <= st_t'(st + 1'b1);
        end
      endcase
    end
  end

  always_comb begin
    cmd    = C_NOP;
    ba_o   = '0;
    addr_o = '0;
    case (st)
      S_PRE1, S_PRE2: begin cmd = C_PRE; addr_o = BIT10; end
      S_EMR: begin cmd = C_LMR; ba_o = BA_W'(1); addr_o = EXT_MODE; end
      S_MRR: begin cmd = C_LMR; addr_o = MODE_BASE | BIT8; end
      S_MRF: begin cmd = C_LMR; addr_o = MODE_BASE; end
      S_REF1, S_REF2: cmd = C_REF;
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o       = !(st == S_IDLE || st == S_PWAIT);
  assign init_done_o = (st == S_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  assert_cke_low_nop_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == 4'b0111 && !done));

  assert_cke_stays_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cke) && !$past(rst) |-> cke);

  assert_rise_is_nop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> cmd == 4'b0111);

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |-> (addr[10] && ba == '0));

  assert_mode_bt_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000 && ba == '0) |-> !addr[3]);

  assert_ref_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0001 |=> cmd == 4'b0111);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_nop_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == 4'b0111 && cke));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cke && !done && cmd == 4'b0111));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .cke(cke_o),
  .cs_n(cs_n_o), .ras_n(ras_n_o), .cas_n(cas_n_o), .we_n(we_n_o),
  .ba(ba_o), .addr(addr_o), .done(init_done_o)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_NS = 10;
  localparam int PWR    = 30;
  localparam int DLL    = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic clk_ok_i = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always #(CLK_NS / 2) clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(13), .BA_W(2), .CLK_PS(CLK_NS * 1000), .POWERUP_NS(PWR * CLK_NS),
    .T_RP(3), .T_MRD(2), .T_RFC(8), .DLL_CYC(DLL),
    .BURST_CODE(3'b010), .CAS_CODE(3'b010), .EXT_MODE(13'h000)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .clk_ok_i(clk_ok_i),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  // {cmd, ba, addr, gap from previous command (or from cke rise), req}
  localparam logic [30:0] EXP [7] = '{
    {4'b0010, 2'd0, 13'h400, 8'd1, 4'd3},  // R3
    {4'b0000, 2'd1, 13'h000, 8'd3, 4'd4},  // R4
    {4'b0000, 2'd0, 13'h122, 8'd2, 4'd5},  // R5
    {4'b0010, 2'd0, 13'h400, 8'd2, 4'd6},  // R6
    {4'b0001, 2'd0, 13'h000, 8'd3, 4'd7},  // R7
    {4'b0001, 2'd0, 13'h000, 8'd8, 4'd7},  // R7
    {4'b0000, 2'd0, 13'h022, 8'd8, 4'd8}   // R8
  };

  int checks = 0;
  int bad = 0;
  logic [3:0]  tc [16];
  logic [1:0]  tb [16];
  logic [12:0] ta [16];
  int          tk [16];
  int ncmd, rise_k, done_k, first_done;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq();
    ncmd = 0; rise_k = -1; done_k = -1;
    @(negedge clk); start_i = 1'b1;
    for (int k = 1; k <= 2000 && done_k < 0; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (cke && rise_k < 0) rise_k = k;
      if (cmd != 4'b0111) begin
        if (ncmd < 16) begin
          tc[ncmd] = cmd; tb[ncmd] = ba; ta[ncmd] = addr; tk[ncmd] = k;
        end
        ncmd++;
      end
      if (done) begin
        done_k = k;
        chk(cmd == 4'b0111, "R9 nop at done", cmd, 4'b0111);
      end
    end
    chk(done_k > 0, "R9 done reached", done_k, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cke == 1'b0, "R1 cke in reset", cke, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cke == 1'b0 && cmd == 4'b0111 && done == 1'b0, "R1 idle", {cke, cmd, done}, 6'b001110);

    start_i = 1'b1;
    repeat (5) @(negedge clk);
    start_i = 1'b0;
    repeat (PWR + 10) @(negedge clk);
    chk(cke == 1'b0 && cmd == 4'b0111, "R1 start without clk_ok ignored", {cke, cmd}, 5'b00111);

    clk_ok_i = 1'b1;
    run_seq();
    first_done = done_k;
    chk(rise_k == PWR + 1, "R2 cke rise cycle", rise_k, PWR + 1);
    chk(ncmd == 7, "R10 command count", ncmd, 7);

    for (int i = 0; i < 7; i++) begin
      automatic logic [30:0] e = EXP[i];
      automatic int prev = (i == 0) ? rise_k : tk[i > 0 ? i - 1 : 0];
      automatic string r = $sformatf("R%0d entry %0d", e[3:0], i);
      chk(tc[i] == e[30:27], {r, " cmd"}, tc[i], e[30:27]);
      chk(tb[i] == e[26:25], {r, " bank"}, tb[i], e[26:25]);
      chk(ta[i] == e[24:12], {r, " addr"}, ta[i], e[24:12]);
      chk(tk[i] - prev == int'(e[11:4]), {r, " gap"}, tk[i] - prev, e[11:4]);
    end

    chk(done_k - tk[2] == DLL + 1, "R9 done after DLL window", done_k - tk[2], DLL + 1);

    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(done && cke && cmd == 4'b0111, "R9 start after done ignored", {done, cke, cmd}, 6'b110111);

    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (PWR + 6) @(negedge clk);
    chk(cke == 1'b1 && done == 1'b0, "R11 mid-sequence", {cke, done}, 2'b10);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cke == 1'b0 && cmd == 4'b0111 && done == 1'b0, "R11 reset state", {cke, cmd, done}, 6'b001110);
    repeat (PWR + 10) @(negedge clk);
    chk(cke == 1'b0, "R11 no restart without start", cke, 0);

    run_seq();
    chk(done_k == first_done, "R11 repeat latency", done_k, first_done);
    chk(ncmd == 7, "R10 repeat count", ncmd, 7);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule